// File: doc/BRIEF.md
# Instruction Fetch Line Buffer

This block sits between an in-order fetch stage and the instruction cache. It keeps a handful of recently filled cache lines, and next to them a separate list of lines whose cache miss has not yet returned. Every entry in either structure is tagged with an address-space identifier and a line-aligned address. Each entry also counts the fetched instructions that are still waiting to be served from it. Only a filled line with no waiters may be displaced, and the choice among such lines is least-recently-used.

The fetch stage presents an instruction request with a slot identifier, an address-space identifier and a program counter. The block answers in the same cycle: the request is accepted or refused, and if the request is a true miss it issues a line-sized read to the cache. Accepted requests wait in their slot until their line is held in the filled-line buffer. One waiting slot is served per cycle, and the selected instruction word is returned one cycle later together with the slot identifier. Returned lines come back on a fill port that the block may hold off. A squash port withdraws one waiting slot and releases its claim on the line it was waiting for.

Top module: `fetch_line_buf`

## Requirements
- R1: An entry matches a request only when both its address-space identifier and its line address (PC with the low log2(LINE_BYTES) bits cleared) are equal to the request's; the same line address under another identifier is a miss.
- R2: A request whose line is in the pending-miss list is accepted (`req_accept`=1) without a cache read (`mreq_valid`=0), and is served after that line's fill, together with the other waiters on that line.
- R3: A request whose line is in the filled-line buffer, while the pending list is not full, is accepted without a cache read, and its instruction appears on the output on the second rising edge after the request is presented.
- R4: While the pending list holds DEPTH entries, a request that misses the pending list is refused (`req_accept`=0, `mreq_valid`=0), even if its line is in the filled-line buffer.
- R5: A request that misses both structures while the pending list has room is accepted, and in the same cycle `mreq_valid` is 1, with `mreq_asid` equal to the request identifier and `mreq_addr` equal to the line-aligned PC.
- R6: The output word is bits [IW*k +: IW] of the line, with IW = 8*INST_BYTES and k = (PC − line address) / INST_BYTES.
- R7: When a fill is installed into a full buffer, it replaces the least-recently-used line whose waiter count is zero; installing a line and serving an instruction from a line each make that line the most recently used.
- R8: At most one slot is served per cycle, the lowest-numbered ready slot first; `inst_valid` pulses for one cycle with `inst_id` set to that slot, and each accepted request is output once.
- R9: A squashed slot is never output. The squash decrements the waiter count of its line, and the other waiters on that line are still served after the fill.
- R10: A pending entry whose waiters have all been squashed is freed. A later fill for that line is accepted (`fill_ready`=1) and discarded without being installed, so a new request for the line misses again.
- R11: `fill_ready` is 0 in any cycle in which an instruction is being selected for output, or in which no line can be replaced.
- R12: After reset both structures and all slots are empty: `inst_valid`=0, `mreq_valid`=0 and `fill_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_id | input | SID_W | Slot identifier of the request (must be free) |
| req_asid | input | ASID_W | Address-space identifier of the request |
| req_pc | input | ADDR_W | Fetch address of the request |
| req_accept | output | 1 | Request taken this cycle; when 0 the request must be retried |
| mreq_valid | output | 1 | Line read issued to the cache |
| mreq_asid | output | ASID_W | Address-space identifier of the line read |
| mreq_addr | output | ADDR_W | Line-aligned address of the line read |
| fill_valid | input | 1 | Returned line present |
| fill_asid | input | ASID_W | Address-space identifier of the returned line |
| fill_addr | input | ADDR_W | Line-aligned address of the returned line |
| fill_data | input | LINE_W | Returned line contents |
| fill_ready | output | 1 | Returned line taken this cycle |
| sq_valid | input | 1 | Squash one waiting slot |
| sq_id | input | SID_W | Slot to squash |
| inst_valid | output | 1 | Instruction word valid |
| inst_id | output | SID_W | Slot that the word belongs to |
| inst_word | output | IW | Selected instruction word |

## Verification
The bench builds the block with DEPTH set to 2 and leaves four slots, 64-byte lines and 32-bit words at their defaults. With only two pending entries and two filled lines, a few requests are enough to fill the pending list, to force a refusal while the wanted line sits in the buffer, and to make each new fill evict a line. This makes the LRU victim order observable through which later requests miss again. Squashes are issued against a shared pending line and against a line with a single waiter, so that both the surviving-waiter path and the discard path can be seen.

// File: rtl/fetch_line_buf.sv
module fetch_line_buf #(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 64,
  parameter int INST_BYTES = 4,
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int NSLOT      = 4,
  parameter int CNT_W      = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int ISH       = $clog2(INST_BYTES),
  localparam int IW        = INST_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int WSEL_W    = OFF_W - ISH,
  localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SID_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SID_W-1:0]  req_id,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              req_accept,
  output logic              mreq_valid,
  output logic [ASID_W-1:0] mreq_asid,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LINE_W-1:0] fill_data,
  output logic              fill_ready,
  input  logic              sq_valid,
  input  logic [SID_W-1:0]  sq_id,
  output logic              inst_valid,
  output logic [SID_W-1:0]  inst_id,
  output logic [IW-1:0]     inst_word
);

  logic [DEPTH-1:0]  b_vld, p_vld;
  logic [ASID_W-1:0] b_asid [DEPTH];
  logic [ASID_W-1:0] p_asid [DEPTH];
  logic [TAG_W-1:0]  b_tag  [DEPTH];
  logic [TAG_W-1:0]  p_tag  [DEPTH];
  logic [CNT_W-1:0]  b_cnt  [DEPTH];
  logic [CNT_W-1:0]  p_cnt  [DEPTH];
  logic [IDX_W-1:0]  b_age  [DEPTH];
  logic [LINE_W-1:0] b_data [DEPTH];

  logic [NSLOT-1:0]  s_vld;
  logic [ASID_W-1:0] s_asid [NSLOT];
  logic [ADDR_W-1:0] s_pc   [NSLOT];

  wire [TAG_W-1:0]  req_tag  = req_pc[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0]  fill_tag = fill_addr[ADDR_W-1:OFF_W];
  wire [ASID_W-1:0] sq_asid  = s_asid[sq_id];
  wire [TAG_W-1:0]  sq_tag   = s_pc[sq_id][ADDR_W-1:OFF_W];

  logic [DEPTH-1:0] rq_ph, rq_bh, sq_ph, sq_bh, fl_ph;
  logic [DEPTH-1:0] sb_hit [NSLOT];
  logic [DEPTH-1:0] p_inc, p_dec, b_inc, b_dsq, b_dsv;

  wire p_full    = &p_vld;
  wire b_full    = &b_vld;
  wire req_p_any = |rq_ph;
  wire req_b_any = !p_full && |rq_bh;
  wire sq_ok     = sq_valid && s_vld[sq_id];
  wire sq_b_any  = |sq_bh;
  wire f_hit     = |fl_ph;

  assign req_accept = req_valid && (req_p_any || !p_full);
  assign mreq_valid = req_accept && !req_p_any && !req_b_any;
  assign mreq_asid  = req_asid;
  assign mreq_addr  = {req_tag, {OFF_W{1'b0}}};

  logic             srv_any;
  logic [SID_W-1:0] srv_sid;
  logic [IDX_W-1:0] srv_ent;
  logic [IDX_W-1:0] p_free, f_pidx, tgt;
  logic             tgt_ok;
  logic [CNT_W-1:0] pn [DEPTH];
  logic [CNT_W-1:0] bn [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign rq_ph[i] = p_vld[i] && p_asid[i] == req_asid && p_tag[i] == req_tag;
    assign rq_bh[i] = b_vld[i] && b_asid[i] == req_asid && b_tag[i] == req_tag;
    assign sq_ph[i] = p_vld[i] && p_asid[i] == sq_asid && p_tag[i] == sq_tag;
    assign sq_bh[i] = b_vld[i] && b_asid[i] == sq_asid && b_tag[i] == sq_tag;
    assign fl_ph[i] = p_vld[i] && p_asid[i] == fill_asid && p_tag[i] == fill_tag;
    assign p_inc[i] = req_accept && rq_ph[i];
    assign p_dec[i] = sq_ok && !sq_b_any && sq_ph[i];
    assign b_inc[i] = req_accept && req_b_any && rq_bh[i];
    assign b_dsq[i] = sq_ok && sq_bh[i];
    assign b_dsv[i] = srv_any && srv_ent == IDX_W'(i);
    assign pn[i] = p_cnt[i] + CNT_W'(p_inc[i]) - CNT_W'(p_dec[i]);
    assign bn[i] = b_cnt[i] + CNT_W'(b_inc[i]) - CNT_W'(b_dsq[i]) - CNT_W'(b_dsv[i]);
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign sb_hit[k][i] = b_vld[i] && b_asid[i] == s_asid[k] &&
                            b_tag[i] == s_pc[k][ADDR_W-1:OFF_W];
    end
  end

  always_comb begin
    srv_any = 1'b0;
    srv_sid = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (s_vld[k] && !(sq_ok && sq_id == SID_W'(k)) && |sb_hit[k]) begin
        srv_any = 1'b1;
        srv_sid = SID_W'(k);
      end
    end
    srv_ent = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sb_hit[srv_sid][i]) srv_ent = IDX_W'(i);
  end

  always_comb begin
    logic [IDX_W-1:0] best;
    p_free = '0;
    f_pidx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (!p_vld[i]) p_free = IDX_W'(i);
    for (int i = 0; i < DEPTH; i++) if (fl_ph[i]) f_pidx = IDX_W'(i);
    tgt    = '0;
    tgt_ok = 1'b0;
    best   = '0;
    if (!b_full) begin
      tgt_ok = 1'b1;
      for (int i = DEPTH - 1; i >= 0; i--) if (!b_vld[i]) tgt = IDX_W'(i);
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (b_cnt[i] == '0 && (!tgt_ok || b_age[i] > best)) begin
          tgt    = IDX_W'(i);
          best   = b_age[i];
          tgt_ok = 1'b1;
        end
      end
    end
  end

  assign fill_ready = !srv_any && tgt_ok && !(req_accept && req_b_any && rq_bh[tgt]);
  wire fill_take = fill_valid && fill_ready;
  wire fill_inst = fill_take && f_hit && pn[f_pidx] != '0;

  wire             mv      = srv_any || fill_inst;
  wire [IDX_W-1:0] mv_idx  = srv_any ? srv_ent : tgt;
  wire [IDX_W:0]   ref_age = (srv_any || b_vld[tgt]) ? {1'b0, b_age[mv_idx]} : (IDX_W+1)'(DEPTH);

  wire [WSEL_W-1:0] wsel     = s_pc[srv_sid][OFF_W-1:ISH];
  wire [IW-1:0]     srv_word = b_data[srv_ent][int'(wsel)*IW +: IW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_vld      <= '0;
      p_vld      <= '0;
      s_vld      <= '0;
      inst_valid <= 1'b0;
      inst_id    <= '0;
      inst_word  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        b_asid[i] <= '0;
        p_asid[i] <= '0;
        b_tag[i]  <= '0;
        p_tag[i]  <= '0;
        b_cnt[i]  <= '0;
        p_cnt[i]  <= '0;
        b_age[i]  <= '0;
        b_data[i] <= '0;
      end
      for (int k = 0; k < NSLOT; k++) begin
        s_asid[k] <= '0;
        s_pc[k]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (p_vld[i]) begin
          p_cnt[i] <= pn[i];
          if (pn[i] == '0) p_vld[i] <= 1'b0;
        end
        if (fill_take && f_hit && f_pidx == IDX_W'(i)) p_vld[i] <= 1'b0;
        if (mreq_valid && p_free == IDX_W'(i)) begin
          p_vld[i]  <= 1'b1;
          p_asid[i] <= req_asid;
          p_tag[i]  <= req_tag;
          p_cnt[i]  <= CNT_W'(1);
        end
        if (b_vld[i]) b_cnt[i] <= bn[i];
        if (mv && b_vld[i] && IDX_W'(i) != mv_idx && {1'b0, b_age[i]} < ref_age)
          b_age[i] <= b_age[i] + 1'b1;
        if (mv && mv_idx == IDX_W'(i)) b_age[i] <= '0;
        if (fill_inst && tgt == IDX_W'(i)) begin
          b_vld[i]  <= 1'b1;
          b_asid[i] <= fill_asid;
          b_tag[i]  <= fill_tag;
          b_cnt[i]  <= pn[f_pidx];
          b_data[i] <= fill_data;
        end
      end
      for (int k = 0; k < NSLOT; k++) begin
        if (srv_any && srv_sid == SID_W'(k)) s_vld[k] <= 1'b0;
        if (sq_ok && sq_id == SID_W'(k)) s_vld[k] <= 1'b0;
        if (req_accept && req_id == SID_W'(k)) begin
          s_vld[k]  <= 1'b1;
          s_asid[k] <= req_asid;
          s_pc[k]   <= req_pc;
        end
      end
      inst_valid <= srv_any;
      inst_id    <= srv_sid;
      inst_word  <= srv_word;
    end
  end

  logic [DEPTH-1:0] cnt_sat, cnt_flr, age_mask;
  logic             ovl;
  always_comb begin
    ovl      = 1'b0;
    age_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt_sat[i] = (b_inc[i] && &b_cnt[i]) || (p_inc[i] && &p_cnt[i]);
      cnt_flr[i] = ((b_dsq[i] || b_dsv[i]) && b_cnt[i] == '0) ||
                   (b_dsq[i] && b_dsv[i] && b_cnt[i] == CNT_W'(1)) ||
                   (p_dec[i] && p_cnt[i] == '0);
      if (b_vld[i]) age_mask[b_age[i]] = 1'b1;
      for (int j = 0; j < DEPTH; j++)
        if (p_vld[i] && b_vld[j] && p_asid[i] == b_asid[j] && p_tag[i] == b_tag[j])
          ovl = 1'b1;
    end
  end

  // R2
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_sat == '0)
    else $error("waiter count would wrap past its maximum");
  // R9
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_flr == '0)
    else $error("waiter count would drop below zero");
  // R7
  lru_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(age_mask) == $countones(b_vld))
    else $error("recency ranks of filled lines are not distinct");
  // R5
  pend_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n) !ovl)
    else $error("line present in both pending list and buffer");
  // R8
  out_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srv_any |=> inst_valid && inst_id == $past(srv_sid))
    else $error("served slot not presented on output");

endmodule

// File: tb/sim_fetch_line_buf.sv
module sim_fetch_line_buf;
  localparam int DEPTH  = 2;
  localparam int NSLOT  = 4;
  localparam int ADDR_W = 32;
  localparam int ASID_W = 8;
  localparam int LINE_W = 512;
  localparam int IW     = 32;
  localparam int SID_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [SID_W-1:0]  req_id = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [ADDR_W-1:0] req_pc = '0;
  logic req_accept, mreq_valid;
  logic [ASID_W-1:0] mreq_asid;
  logic [ADDR_W-1:0] mreq_addr;
  logic fill_valid = 1'b0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [LINE_W-1:0] fill_data = '0;
  logic fill_ready;
  logic sq_valid = 1'b0;
  logic [SID_W-1:0] sq_id = '0;
  logic inst_valid;
  logic [SID_W-1:0] inst_id;
  logic [IW-1:0] inst_word;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fetch_line_buf #(.DEPTH(DEPTH), .NSLOT(NSLOT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_id(req_id), .req_asid(req_asid), .req_pc(req_pc),
    .req_accept(req_accept), .mreq_valid(mreq_valid), .mreq_asid(mreq_asid),
    .mreq_addr(mreq_addr), .fill_valid(fill_valid), .fill_asid(fill_asid),
    .fill_addr(fill_addr), .fill_data(fill_data), .fill_ready(fill_ready),
    .sq_valid(sq_valid), .sq_id(sq_id),
    .inst_valid(inst_valid), .inst_id(inst_id), .inst_word(inst_word));

  function automatic logic [IW-1:0] wexp(input logic [7:0] asid, input logic [31:0] pc);
    return {pc[31:2], 2'b00} ^ 32'h5A5A_0000 ^ {asid, 24'h0};
  endfunction

  function automatic logic [LINE_W-1:0] mkline(input logic [7:0] asid, input logic [31:0] la);
    logic [LINE_W-1:0] d;
    for (int k = 0; k < 16; k++) d[k*32 +: 32] = wexp(asid, la + 32'(k * 4));
    return d;
  endfunction

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] id, input logic [7:0] asid, input logic [31:0] pc,
                        input logic exp_acc, input logic exp_mr, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_id = id; req_asid = asid; req_pc = pc;
    #1;
    check({tag, " accept"}, 64'(req_accept), 64'(exp_acc));
    check({tag, " mreq_valid"}, 64'(mreq_valid), 64'(exp_mr));
    if (exp_mr) begin
      check({tag, " mreq_addr"}, 64'(mreq_addr), 64'({pc[31:6], 6'b0}));
      check({tag, " mreq_asid"}, 64'(mreq_asid), 64'(asid));
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [7:0] asid, input logic [31:0] la,
                         input logic exp_rdy, input string tag);
    @(negedge clk);
    fill_valid = 1'b1; fill_asid = asid; fill_addr = la; fill_data = mkline(asid, la);
    #1;
    check({tag, " fill_ready"}, 64'(fill_ready), 64'(exp_rdy));
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic do_sq(input logic [1:0] id);
    @(negedge clk);
    sq_valid = 1'b1; sq_id = id;
    @(posedge clk); #1;
    sq_valid = 1'b0;
  endtask

  task automatic inst_now(input logic [1:0] id, input logic [7:0] asid,
                          input logic [31:0] pc, input string tag);
    check({tag, " inst_valid"}, 64'(inst_valid), 64'(1));
    check({tag, " inst_id"}, 64'(inst_id), 64'(id));
    check({tag, " inst_word"}, 64'(inst_word), 64'(wexp(asid, pc)));
  endtask

  task automatic expect_inst(input logic [1:0] id, input logic [7:0] asid,
                             input logic [31:0] pc, input string tag);
    @(posedge clk); #1;
    inst_now(id, asid, pc, tag);
  endtask

  task automatic expect_none(input string tag);
    @(posedge clk); #1;
    check({tag, " no inst"}, 64'(inst_valid), 64'(0));
  endtask

  task automatic t_reset;
    check("R12 inst_valid", 64'(inst_valid), 64'(0));
    check("R12 mreq_valid", 64'(mreq_valid), 64'(0));
    check("R12 fill_ready", 64'(fill_ready), 64'(1));
  endtask

  task automatic t_miss_fill;
    do_req(2'd0, 8'd1, 32'h1000_0048, 1'b1, 1'b1, "R5 miss");
    do_fill(8'd1, 32'h1000_0040, 1'b1, "R5 fill");
    expect_inst(2'd0, 8'd1, 32'h1000_0048, "R6 word select");
  endtask

  task automatic t_hit;
    do_req(2'd1, 8'd1, 32'h1000_0054, 1'b1, 1'b0, "R3 hit");
    expect_inst(2'd1, 8'd1, 32'h1000_0054, "R3 hit output");
  endtask

  task automatic t_asid;
    do_req(2'd2, 8'd2, 32'h1000_0048, 1'b1, 1'b1, "R1 other asid");
    do_fill(8'd2, 32'h1000_0040, 1'b1, "R1 fill");
    expect_inst(2'd2, 8'd2, 32'h1000_0048, "R1 asid word");
  endtask

  task automatic t_merge;
    do_req(2'd0, 8'd1, 32'h2000_0000, 1'b1, 1'b1, "R2 first miss");
    do_req(2'd1, 8'd1, 32'h2000_000C, 1'b1, 1'b0, "R2 merged");
    expect_none("R2 before fill");
    do_fill(8'd1, 32'h2000_0000, 1'b1, "R2 fill");
    expect_inst(2'd0, 8'd1, 32'h2000_0000, "R8 lowest slot first");
    expect_inst(2'd1, 8'd1, 32'h2000_000C, "R2 merged waiter");
    expect_none("R8 single output");
  endtask

  task automatic t_lru;
    do_req(2'd2, 8'd2, 32'h1000_0040, 1'b1, 1'b0, "R7 touch A2");
    expect_inst(2'd2, 8'd2, 32'h1000_0040, "R7 touch output");
    do_req(2'd3, 8'd1, 32'h3000_0000, 1'b1, 1'b1, "R7 miss C");
    do_fill(8'd1, 32'h3000_0000, 1'b1, "R7 fill C");
    expect_inst(2'd3, 8'd1, 32'h3000_0000, "R7 C output");
    do_req(2'd0, 8'd2, 32'h1000_0044, 1'b1, 1'b0, "R7 recent line kept");
    expect_inst(2'd0, 8'd2, 32'h1000_0044, "R7 kept output");
    do_req(2'd1, 8'd1, 32'h2000_0000, 1'b1, 1'b1, "R7 older line evicted");
    do_fill(8'd1, 32'h2000_0000, 1'b1, "R7 refill B");
    expect_inst(2'd1, 8'd1, 32'h2000_0000, "R7 refill output");
  endtask

  task automatic t_stall;
    do_req(2'd2, 8'd1, 32'h2000_0004, 1'b1, 1'b0, "R11 hit");
    do_fill(8'd7, 32'h7000_0000, 1'b0, "R11 fill held");
    inst_now(2'd2, 8'd1, 32'h2000_0004, "R11 served");
    expect_none("R11 quiet");
  endtask

  task automatic t_full;
    do_req(2'd0, 8'd3, 32'h4000_0000, 1'b1, 1'b1, "R4 miss X");
    do_req(2'd1, 8'd3, 32'h5000_0000, 1'b1, 1'b1, "R4 miss Y");
    do_req(2'd2, 8'd2, 32'h1000_0040, 1'b0, 1'b0, "R4 refused buffered");
    do_req(2'd2, 8'd3, 32'h4000_0010, 1'b1, 1'b0, "R4 pending hit");
  endtask

  task automatic t_squash;
    do_sq(2'd1);
    do_sq(2'd0);
    do_fill(8'd3, 32'h5000_0000, 1'b1, "R10 discard fill");
    expect_none("R10 nothing out");
    do_fill(8'd3, 32'h4000_0000, 1'b1, "R9 fill shared");
    expect_inst(2'd2, 8'd3, 32'h4000_0010, "R9 survivor");
    expect_none("R9 squashed silent");
    do_req(2'd0, 8'd3, 32'h5000_0000, 1'b1, 1'b1, "R10 line not installed");
    do_fill(8'd3, 32'h5000_0000, 1'b1, "R10 refill");
    expect_inst(2'd0, 8'd3, 32'h5000_0000, "R10 refill output");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_miss_fill();
    t_hit();
    t_asid();
    t_merge();
    t_lru();
    t_stall();
    t_full();
    t_squash();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule